// File: doc/BRIEF.md
# Disk Controller DMA Request and Acknowledge Handshake

This block drives the DMA request line of a floppy-style disk controller while a data-transfer command is in its execution phase. It also turns the DMA controller's acknowledge and bus strobes into single-cycle read and write strobes for the controller's data FIFO. The request is raised by the controller itself. It is only allowed when DMA has been switched on by the drive-timing setup command and a data transfer is running.

The block has two modes. In byte mode (FIFO disabled) it asks for one byte at a time and drops the request as soon as that byte is acknowledged. In FIFO mode the request works with hysteresis. It rises when the FIFO crosses a programmable threshold and falls only when the FIFO is drained on a read or filled on a write. The acknowledge alone selects the FIFO, and no bus address takes part. When an external DMA controller runs a verify cycle, it asserts the acknowledge with neither bus strobe. In byte mode on a read, the block reports that cycle as a pseudo read. With the FIFO enabled, verification is done by a dedicated command and the request stays low.

Top module: `fdc_dma_req`

## Requirements
- R1: When `dma_en` is low in a cycle, `drq` is low in the following cycle.
- R2: When `xfer_active` is low in a cycle, `drq` is low in the following cycle.
- R3: Byte mode (`fifo_en`=0). With `drq` low, `dack_n` high and request allowed, `drq` rises one cycle after a byte is pending. A byte is pending when `fifo_level`≠0 if `dir_rd`=1, and when `fifo_level`=0 if `dir_rd`=0. `drq` falls one cycle after `dack_n` goes low. It does not rise again while `dack_n` stays low.
- R4: FIFO mode, read (`fifo_en`=1, `dir_rd`=1). `drq` rises one cycle after `fifo_level` ≥ `fifo_thresh` and `fifo_level`≠0. Once high, it stays high until the cycle after `fifo_level` is 0.
- R5: FIFO mode, write (`dir_rd`=0). `drq` rises one cycle after FIFO_DEPTH−`fifo_level` ≥ `fifo_thresh` and `fifo_level`≠FIFO_DEPTH. Once high, it stays high until the cycle after `fifo_level` equals FIFO_DEPTH.
- R6: `fifo_rd` pulses high for exactly one cycle. The pulse comes one cycle after the first cycle in which `dack_n` and `ior_n` are both low, with `dir_rd`=1, `dma_en`=1 and `xfer_active`=1. It never pulses when `dir_rd`=0.
- R7: `fifo_wr` pulses high for exactly one cycle. The pulse comes one cycle after the first cycle in which `dack_n` and `iow_n` are both low, with `dir_rd`=0, `dma_en`=1 and `xfer_active`=1. It never pulses when `dir_rd`=1.
- R8: `pseudo_rd` pulses high for one cycle, one cycle after `dack_n` falls while `ior_n` and `iow_n` are both high, with `fifo_en`=0, `dir_rd`=1, `dma_en`=1 and `xfer_active`=1. In that case `fifo_rd` stays low.
- R9: `pseudo_rd` stays low when `fifo_en`=1 or `dir_rd`=0.
- R10: When `fifo_en`=1 and `verify_cmd`=1 in a cycle, `drq` is low in the following cycle.
- R11: While `rst_n` is low, `drq`, `fifo_rd`, `fifo_wr` and `pseudo_rd` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_en | input | 1 | DMA enabled by the timing setup command |
| xfer_active | input | 1 | Data-transfer execution phase is running |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = byte mode |
| dir_rd | input | 1 | 1 = disk-to-host read, 0 = host-to-disk write |
| verify_cmd | input | 1 | Current command is a verify |
| fifo_level | input | LVL_W | Bytes currently held in the FIFO |
| fifo_thresh | input | LVL_W | Programmable request threshold |
| dack_n | input | 1 | DMA acknowledge, active low |
| ior_n | input | 1 | Bus read strobe, active low |
| iow_n | input | 1 | Bus write strobe, active low |
| drq | output | 1 | DMA request |
| fifo_rd | output | 1 | One-cycle FIFO read strobe |
| fifo_wr | output | 1 | One-cycle FIFO write strobe |
| pseudo_rd | output | 1 | One-cycle verify-mode pseudo-read indication |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that a bus strobe is asserted in the same cycle as the acknowledge edge it belongs to, so that a cycle with the acknowledge but no strobe can be read as a verify cycle. The stimulus changes all inputs only on falling clock edges. It always lowers a strobe together with `dack_n` and always releases the acknowledge before the next DMA cycle. The threshold and level sweeps stay within 0 to FIFO_DEPTH.

// File: rtl/fdc_dma_pkg.sv
// Shared definitions for the disk-controller DMA handshake.
// Assumes nothing beyond being compiled before the modules that import it.
package fdc_dma_pkg;

    // Default data FIFO depth in bytes
    localparam int DEF_FIFO_DEPTH = 8;

    // Transfer mode as seen by the request generator
    typedef enum logic [1:0] {
        MODE_BYTE_WR = 2'b00,
        MODE_BYTE_RD = 2'b01,
        MODE_FIFO_WR = 2'b10,
        MODE_FIFO_RD = 2'b11
    } xfer_mode_e;

    // Build the mode code from the FIFO-enable and direction flags
    function automatic xfer_mode_e make_mode(input logic fifo_en, input logic dir_rd);
        return xfer_mode_e'({fifo_en, dir_rd});
    endfunction

endpackage

// File: rtl/fdc_req_gen.sv
// DMA request generator.
// In byte mode it requests one byte at a time and drops the request on the
// acknowledge. In FIFO mode it requests with threshold/empty-or-full
// hysteresis. Assumes level and threshold never exceed FIFO_DEPTH.
module fdc_req_gen
    import fdc_dma_pkg::*;
#(
    parameter  int FIFO_DEPTH = DEF_FIFO_DEPTH,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_allow,
    input  xfer_mode_e       mode,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] fifo_thresh,
    input  logic             ack_act,
    output logic             drq
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

    logic [LVL_W-1:0] space;
    logic             start_c;
    logic             stop_c;

    // Free space in the FIFO
    assign space = FULL_LVL - fifo_level;

    // Start and stop conditions for each transfer mode
    always_comb begin
        start_c = 1'b0;
        stop_c  = 1'b0;
        unique case (mode)
            MODE_BYTE_RD: begin
                start_c = (fifo_level != '0) && !ack_act;
                stop_c  = ack_act;
            end
            MODE_BYTE_WR: begin
                start_c = (fifo_level == '0) && !ack_act;
                stop_c  = ack_act;
            end
            MODE_FIFO_RD: begin
                start_c = (fifo_level >= fifo_thresh) && (fifo_level != '0);
                stop_c  = (fifo_level == '0);
            end
            MODE_FIFO_WR: begin
                start_c = (space >= fifo_thresh) && (fifo_level != FULL_LVL);
                stop_c  = (fifo_level == FULL_LVL);
            end
            default: ;
        endcase
    end

    // Request register with set/clear hysteresis
    always_ff @(posedge clk) begin
        if (!rst_n || !req_allow) begin
            drq <= 1'b0;
        end else if (drq) begin
            drq <= !stop_c;
        end else begin
            drq <= start_c;
        end
    end

endmodule

// File: rtl/fdc_ack_decode.sv
// Acknowledge decoder.
// The active-low acknowledge alone selects the FIFO; no address is used.
// It emits one-cycle FIFO strobes and a verify-mode pseudo read.
// Assumes synchronous inputs and that a bus strobe comes with the
// acknowledge edge.
module fdc_ack_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_ok,
    input  logic fifo_en,
    input  logic dir_rd,
    input  logic dack_n,
    input  logic ior_n,
    input  logic iow_n,
    output logic fifo_rd,
    output logic fifo_wr,
    output logic pseudo_rd
);

    logic ack;
    logic rd_now, wr_now, ps_now;
    logic rd_prev, wr_prev, ack_prev;

    // Qualified access conditions in the current cycle
    always_comb begin
        ack    = sel_ok && !dack_n;
        rd_now = ack && dir_rd && !ior_n;
        wr_now = ack && !dir_rd && !iow_n;
        ps_now = ack && !ack_prev && dir_rd && !fifo_en && ior_n && iow_n;
    end

    // History of the access conditions for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev  <= 1'b0;
            wr_prev  <= 1'b0;
            ack_prev <= 1'b0;
        end else begin
            rd_prev  <= rd_now;
            wr_prev  <= wr_now;
            ack_prev <= ack;
        end
    end

    // One-cycle output strobes on the leading edge of each access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_rd   <= 1'b0;
            fifo_wr   <= 1'b0;
            pseudo_rd <= 1'b0;
        end else begin
            fifo_rd   <= rd_now && !rd_prev;
            fifo_wr   <= wr_now && !wr_prev;
            pseudo_rd <= ps_now;
        end
    end

endmodule

// File: rtl/fdc_dma_req.sv
// DMA request / acknowledge handshake for a disk controller data phase.
// It combines the request generator and the acknowledge decoder.
// Requests are allowed only while DMA is enabled and a transfer is running,
// and never during a FIFO-mode verify command.
module fdc_dma_req
    import fdc_dma_pkg::*;
#(
    parameter  int FIFO_DEPTH = DEF_FIFO_DEPTH,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic             xfer_active,
    input  logic             fifo_en,
    input  logic             dir_rd,
    input  logic             verify_cmd,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] fifo_thresh,
    input  logic             dack_n,
    input  logic             ior_n,
    input  logic             iow_n,
    output logic             drq,
    output logic             fifo_rd,
    output logic             fifo_wr,
    output logic             pseudo_rd
);

    logic       sel_ok;
    logic       req_allow;
    xfer_mode_e mode;

    // Qualification shared by both halves
    assign sel_ok    = dma_en && xfer_active;
    assign req_allow = sel_ok && !(fifo_en && verify_cmd);
    assign mode      = make_mode(fifo_en, dir_rd);

    fdc_req_gen #(.FIFO_DEPTH(FIFO_DEPTH)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_allow   (req_allow),
        .mode        (mode),
        .fifo_level  (fifo_level),
        .fifo_thresh (fifo_thresh),
        .ack_act     (!dack_n),
        .drq         (drq)
    );

    fdc_ack_decode u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_ok    (sel_ok),
        .fifo_en   (fifo_en),
        .dir_rd    (dir_rd),
        .dack_n    (dack_n),
        .ior_n     (ior_n),
        .iow_n     (iow_n),
        .fifo_rd   (fifo_rd),
        .fifo_wr   (fifo_wr),
        .pseudo_rd (pseudo_rd)
    );

endmodule

// File: rtl/fdc_dma_req_chk.sv
// Property checker for fdc_dma_req, attached by bind.
// Assumes synchronous inputs; observes ports only.
module fdc_dma_req_chk #(
    parameter  int FIFO_DEPTH = 8,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_en,
    input logic             xfer_active,
    input logic             fifo_en,
    input logic             dir_rd,
    input logic             verify_cmd,
    input logic [LVL_W-1:0] fifo_level,
    input logic             dack_n,
    input logic             drq,
    input logic             fifo_rd,
    input logic             fifo_wr,
    input logic             pseudo_rd
);

    // R1
    dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !drq);

    // R2
    no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> !drq);

    // R3
    byte_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !dack_n) |=> !drq);

    // R4
    rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && dir_rd && fifo_level == '0) |=> !drq);

    // R5
    wr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !dir_rd && fifo_level == LVL_W'(FIFO_DEPTH)) |=> !drq);

    // R6
    rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_rd |=> !fifo_rd);

    // R7
    wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rd |=> !fifo_wr);

    // R8
    pseudo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pseudo_rd && fifo_rd));

    // R9
    pseudo_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en || !dir_rd) |=> !pseudo_rd);

    // R10
    fifo_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && verify_cmd) |=> !drq);

endmodule

bind fdc_dma_req fdc_dma_req_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_en      (dma_en),
    .xfer_active (xfer_active),
    .fifo_en     (fifo_en),
    .dir_rd      (dir_rd),
    .verify_cmd  (verify_cmd),
    .fifo_level  (fifo_level),
    .dack_n      (dack_n),
    .drq         (drq),
    .fifo_rd     (fifo_rd),
    .fifo_wr     (fifo_wr),
    .pseudo_rd   (pseudo_rd)
);

// File: tb/sim_fdc_dma_req.sv
// Self-checking bench: sweeps modes, levels and thresholds exhaustively.
module sim_fdc_dma_req;

    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dma_en, xfer_active, fifo_en, dir_rd, verify_cmd;
    logic [LW-1:0] fifo_level, fifo_thresh;
    logic          dack_n, ior_n, iow_n;
    logic          drq, fifo_rd, fifo_wr, pseudo_rd;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    fdc_dma_req #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .xfer_active(xfer_active),
        .fifo_en(fifo_en), .dir_rd(dir_rd), .verify_cmd(verify_cmd),
        .fifo_level(fifo_level), .fifo_thresh(fifo_thresh),
        .dack_n(dack_n), .ior_n(ior_n), .iow_n(iow_n),
        .drq(drq), .fifo_rd(fifo_rd), .fifo_wr(fifo_wr), .pseudo_rd(pseudo_rd)
    );

    // Advance one clock; returns at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare one output against its expected value
    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Expected drq after one cycle from idle
    function automatic logic exp_start(input logic en, input logic xa, input logic fe,
                                       input logic rd, input logic vf, input int lvl, input int thr);
        if (!en || !xa || (fe && vf)) return 1'b0;
        if (!fe) return rd ? (lvl != 0) : (lvl == 0);
        if (rd) return (lvl >= thr) && (lvl != 0);
        return ((DEPTH - lvl) >= thr) && (lvl != DEPTH);
    endfunction

    initial begin
        rst_n = 1'b0; dma_en = 1'b0; xfer_active = 1'b0; fifo_en = 1'b0;
        dir_rd = 1'b1; verify_cmd = 1'b0; fifo_level = '0; fifo_thresh = '0;
        dack_n = 1'b1; ior_n = 1'b1; iow_n = 1'b1;
        @(negedge clk);
        // R11: reset holds every output low even with a request pending
        dma_en = 1'b1; xfer_active = 1'b1; fifo_level = LW'(1);
        dack_n = 1'b0; ior_n = 1'b0;
        tick(); tick();
        chk("R11", "drq", drq, 1'b0);
        chk("R11", "fifo_rd", fifo_rd, 1'b0);
        chk("R11", "fifo_wr", fifo_wr, 1'b0);
        chk("R11", "pseudo_rd", pseudo_rd, 1'b0);
        dack_n = 1'b1; ior_n = 1'b1;
        rst_n = 1'b1;
        tick();

        // Sweep of request start over every flag, level and threshold
        for (int f = 0; f < 32; f++) begin
            for (int l = 0; l <= DEPTH; l++) begin
                for (int t = 0; t <= DEPTH; t++) begin
                    string tg;
                    xfer_active = 1'b0; tick();
                    dma_en = f[0]; xfer_active = f[1]; fifo_en = f[2];
                    dir_rd = f[3]; verify_cmd = f[4];
                    fifo_level = LW'(l); fifo_thresh = LW'(t);
                    tick();
                    if (!f[0]) tg = "R1";
                    else if (!f[1]) tg = "R2";
                    else if (f[2] && f[4]) tg = "R10";
                    else if (!f[2]) tg = "R3";
                    else if (f[3]) tg = "R4";
                    else tg = "R5";
                    chk(tg, "drq start", drq, exp_start(f[0], f[1], f[2], f[3], f[4], l, t));
                end
            end
        end

        // FIFO-mode hysteresis: once raised, drq holds until empty or full
        dma_en = 1'b1; xfer_active = 1'b1; fifo_en = 1'b1; verify_cmd = 1'b0;
        for (int r = 0; r < 2; r++) begin
            for (int t = 1; t <= DEPTH; t++) begin
                for (int l = 0; l <= DEPTH; l++) begin
                    dir_rd = r[0]; fifo_thresh = LW'(t);
                    fifo_level = r[0] ? LW'(DEPTH) : LW'(0);
                    tick();
                    chk(r[0] ? "R4" : "R5", "drq raise", drq, 1'b1);
                    fifo_level = LW'(l);
                    tick();
                    chk(r[0] ? "R4" : "R5", "drq hold", drq, r[0] ? (l != 0) : (l != DEPTH));
                end
            end
        end

        // Byte-mode read handshake with FIFO read strobe
        xfer_active = 1'b0; tick();
        xfer_active = 1'b1; fifo_en = 1'b0; dir_rd = 1'b1; fifo_level = LW'(1);
        tick();
        chk("R3", "byte rd raise", drq, 1'b1);
        dack_n = 1'b0; ior_n = 1'b0;
        tick();
        chk("R3", "drop on ack", drq, 1'b0);
        chk("R6", "fifo_rd pulse", fifo_rd, 1'b1);
        chk("R8", "no pseudo with ior", pseudo_rd, 1'b0);
        tick();
        chk("R3", "stay low during ack", drq, 1'b0);
        chk("R6", "fifo_rd one cycle", fifo_rd, 1'b0);
        dack_n = 1'b1; ior_n = 1'b1;
        tick();
        chk("R3", "re-raise after ack", drq, 1'b1);
        // R7: write strobe ignored in read direction
        dack_n = 1'b0; iow_n = 1'b0;
        tick();
        chk("R7", "no fifo_wr on read", fifo_wr, 1'b0);
        dack_n = 1'b1; iow_n = 1'b1;
        tick();

        // Byte-mode write handshake with FIFO write strobe
        dir_rd = 1'b0; fifo_level = '0;
        tick();
        chk("R3", "byte wr raise", drq, 1'b1);
        dack_n = 1'b0; iow_n = 1'b0;
        tick();
        chk("R3", "wr drop on ack", drq, 1'b0);
        chk("R7", "fifo_wr pulse", fifo_wr, 1'b1);
        tick();
        chk("R7", "fifo_wr one cycle", fifo_wr, 1'b0);
        dack_n = 1'b1; iow_n = 1'b1;
        tick();
        // R6: read strobe ignored in write direction
        dack_n = 1'b0; ior_n = 1'b0;
        tick();
        chk("R6", "no fifo_rd on write", fifo_rd, 1'b0);
        chk("R9", "no pseudo on write", pseudo_rd, 1'b0);
        dack_n = 1'b1; ior_n = 1'b1;
        tick();

        // Verify-mode pseudo read in byte mode
        dir_rd = 1'b1; fifo_level = LW'(1);
        tick();
        dack_n = 1'b0;
        tick();
        chk("R8", "pseudo_rd pulse", pseudo_rd, 1'b1);
        chk("R8", "no fifo_rd", fifo_rd, 1'b0);
        tick();
        chk("R8", "pseudo_rd one cycle", pseudo_rd, 1'b0);
        dack_n = 1'b1;
        tick();
        // R9: no pseudo read in FIFO mode or write direction
        fifo_en = 1'b1;
        tick();
        dack_n = 1'b0;
        tick();
        chk("R9", "no pseudo fifo mode", pseudo_rd, 1'b0);
        dack_n = 1'b1; fifo_en = 1'b0; dir_rd = 1'b0;
        tick();
        dack_n = 1'b0;
        tick();
        chk("R9", "no pseudo write dir", pseudo_rd, 1'b0);
        dack_n = 1'b1;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule